// File: doc/BRIEF.md
# Register-List Transfer Sequencer

This block sits in the issue stage of a five-stage in-order pipeline. It takes one instruction that moves a list of registers to or from memory and turns it into a stream of single-word micro-operations. Decode hands it a register-list bitmask, a base byte address and a direction flag over a valid/ready handshake. The sequencer then issues one micro-op per cycle, with its register index, word address, direction and first/last markers.

While a sequence is running, the block holds fetch and decode with a stall output. The issue stage is therefore occupied for N consecutive cycles for an N-word transfer. A one-word list behaves like a plain single load or store. A two-word list covers the double-word case. The last marker tells the forwarding logic which micro-op carries the result that dependent instructions may take. Store micro-ops carry no data: the data is read later, when each micro-op reaches the memory stage.

Top module: `lsmSequencer`

## Requirements
- R1: After reset the block is idle: `inReady` is 1, and `uopValid` and `stallUp` are 0.
- R2: An instruction is accepted on a clock edge where `inValid` and `inReady` are both 1. If its mask is nonzero, the first micro-op is presented with `uopValid`=1 and `uopFirst`=1 in the cycle right after that edge.
- R3: A mask with N set bits produces exactly N micro-ops, in N back-to-back cycles, with no gaps. No micro-op follows the one marked last.
- R4: Registers are issued in ascending index order. Each `uopReg` is the index of a bit that is set in the mask.
- R5: The micro-op numbered k (counting from 0) carries the address `inBase + 4*k`, modulo 2^AW.
- R6: `uopFirst` is 1 only on micro-op 0. `uopLast` is 1 only on micro-op N-1. A one-word transfer has both markers set on its single micro-op.
- R7: `uopStore` matches the direction flag captured at acceptance (1 = store, 0 = load) on every micro-op of the sequence.
- R8: `stallUp` is 1 from the cycle after acceptance up to and including the cycle of the last micro-op, and 0 otherwise. `inReady` is 0 in those same cycles, and an `inValid` offered then is ignored.
- R9: An instruction whose mask is all zeros is accepted but produces no micro-ops. `stallUp` stays 0 and `inReady` stays 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Decode offers an instruction |
| inReady | output | 1 | Sequencer is idle and can take an instruction |
| inMask | input | NREGS | Register-list bitmask, bit i selects register i |
| inBase | input | AW | Byte address of the first word |
| inStore | input | 1 | 1 = store to memory, 0 = load from memory |
| uopValid | output | 1 | A micro-op is presented this cycle |
| uopReg | output | $clog2(NREGS) | Register index of the micro-op |
| uopAddr | output | AW | Word address of the micro-op |
| uopStore | output | 1 | Direction of the micro-op |
| uopFirst | output | 1 | Marks the first micro-op of a sequence |
| uopLast | output | 1 | Marks the final micro-op, the one whose result is forwarded |
| stallUp | output | 1 | Holds fetch and decode while a sequence runs |

## Verification
The bench sweeps every pattern of the low eight mask bits. It adds sparse, 12-word, full and end-bit masks, with both directions and with base addresses that wrap.

Each corner targets a specific fault:
- A wrong priority encoder would skip registers or issue them out of order.
- An off-by-one in the last-detect would drop or add one micro-op, or leave `stallUp` up one cycle too long.
- A missing first/last marker on a one-word list would break the single-transfer case.

The bench also offers a second instruction while a sequence is running. A design that accepted it would start an extra sequence after the current one ends.

// File: rtl/lsmPkg.sv
package lsmPkg;
  typedef struct packed {
    logic load;   // capture a new register list
    logic step;   // retire the current micro-op and advance
  } lsmStrobeT;
endpackage

// File: rtl/lsmCtrl.sv
module lsmCtrl
  import lsmPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inMaskAny,
  input  logic      lastNow,
  output lsmStrobeT strobes,
  output logic      busy,
  output logic      first
);
  logic accept;

  assign accept        = inValid && !busy;
  assign strobes.load  = accept && inMaskAny;
  assign strobes.step  = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      first <= 1'b0;
    end else begin
      if (strobes.load) begin
        busy  <= 1'b1;
        first <= 1'b1;
      end else if (strobes.step) begin
        first <= 1'b0;
        if (lastNow) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsmDatapath.sv
module lsmDatapath
  import lsmPkg::*;
#(
  parameter int NREGS      = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  localparam int REGW      = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lsmStrobeT        strobes,
  input  logic [NREGS-1:0] inMask,
  input  logic [AW-1:0]    inBase,
  input  logic             inStore,
  output logic [REGW-1:0]  curReg,
  output logic [AW-1:0]    curAddr,
  output logic             curStore,
  output logic             lastNow
);
  logic [NREGS-1:0] remMask;
  logic [NREGS-1:0] lowBit;

  assign lowBit  = remMask & (~remMask + NREGS'(1));
  assign lastNow = (remMask & (remMask - NREGS'(1))) == '0;

  always_comb begin
    curReg = '0;
    for (int i = NREGS - 1; i >= 0; i--) begin
      if (remMask[i]) curReg = REGW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remMask  <= '0;
      curAddr  <= '0;
      curStore <= 1'b0;
    end else if (strobes.load) begin
      remMask  <= inMask;
      curAddr  <= inBase;
      curStore <= inStore;
    end else if (strobes.step) begin
      remMask  <= remMask & ~lowBit;
      curAddr  <= curAddr + AW'(WORD_BYTES);
    end
  end
endmodule

// File: rtl/lsmSequencer.sv
module lsmSequencer
  import lsmPkg::*;
#(
  parameter int NREGS      = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  localparam int REGW      = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [NREGS-1:0] inMask,
  input  logic [AW-1:0]    inBase,
  input  logic             inStore,
  output logic             uopValid,
  output logic [REGW-1:0]  uopReg,
  output logic [AW-1:0]    uopAddr,
  output logic             uopStore,
  output logic             uopFirst,
  output logic             uopLast,
  output logic             stallUp
);
  lsmStrobeT strobes;
  logic      busy;
  logic      first;
  logic      lastNow;

  lsmCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMaskAny(|inMask),
    .lastNow(lastNow), .strobes(strobes), .busy(busy), .first(first)
  );

  lsmDatapath #(.NREGS(NREGS), .AW(AW), .WORD_BYTES(WORD_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inMask(inMask),
    .inBase(inBase), .inStore(inStore), .curReg(uopReg),
    .curAddr(uopAddr), .curStore(uopStore), .lastNow(lastNow)
  );

  assign inReady  = !busy;
  assign stallUp  = busy;
  assign uopValid = busy;
  assign uopFirst = first;
  assign uopLast  = busy && lastNow;
endmodule

// File: rtl/lsmSequencerChk.sv
module lsmSequencerChk #(
  parameter int NREGS      = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  localparam int REGW      = $clog2(NREGS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [NREGS-1:0] inMask,
  input logic             uopValid,
  input logic [REGW-1:0]  uopReg,
  input logic [AW-1:0]    uopAddr,
  input logic             uopStore,
  input logic             uopFirst,
  input logic             uopLast,
  input logic             stallUp
);
  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && (inMask != '0) |=> uopValid && uopFirst);
  // R3
  no_uop_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && uopLast |=> !uopValid);
  // R3
  no_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopLast |=> uopValid && !uopFirst);
  // R4
  ascending_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopLast |=> uopReg > $past(uopReg));
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopLast |=> uopAddr == $past(uopAddr) + AW'(WORD_BYTES));
  // R7
  store_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopLast |=> $stable(uopStore));
  // R8
  stall_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallUp |-> !inReady);
  // R9
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && (inMask == '0) |=> !uopValid && !stallUp);
  // R6
  first_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopFirst || uopLast) |-> uopValid);
endmodule

bind lsmSequencer lsmSequencerChk #(.NREGS(NREGS), .AW(AW), .WORD_BYTES(WORD_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inMask(inMask),
  .uopValid(uopValid), .uopReg(uopReg), .uopAddr(uopAddr), .uopStore(uopStore),
  .uopFirst(uopFirst), .uopLast(uopLast), .stallUp(stallUp)
);

// File: tb/lsmSequencer_test.sv
module lsmSequencer_test;
  localparam int NREGS = 16;
  localparam int AW    = 32;
  localparam int REGW  = $clog2(NREGS);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [NREGS-1:0] inMask = '0;
  logic [AW-1:0]    inBase = '0;
  logic             inStore = 1'b0;
  logic             uopValid;
  logic [REGW-1:0]  uopReg;
  logic [AW-1:0]    uopAddr;
  logic             uopStore;
  logic             uopFirst;
  logic             uopLast;
  logic             stallUp;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  lsmSequencer #(.NREGS(NREGS), .AW(AW)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inMask(inMask), .inBase(inBase), .inStore(inStore),
    .uopValid(uopValid), .uopReg(uopReg), .uopAddr(uopAddr),
    .uopStore(uopStore), .uopFirst(uopFirst), .uopLast(uopLast),
    .stallUp(stallUp)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (mask %h)", req, act, exp, inMask);
    end
  endtask

  // Drives one instruction and follows its micro-ops cycle by cycle.
  task automatic runInst(input logic [NREGS-1:0] m, input logic [AW-1:0] b, input logic st);
    int n = 0;
    int k = 0;
    for (int i = 0; i < NREGS; i++) if (m[i]) n++;
    chk("R8 ready when idle", inReady, 1);
    inValid = 1'b1; inMask = m; inBase = b; inStore = st;
    @(negedge clk);
    inValid = 1'b0;
    if (n == 0) begin
      chk("R9 no uop", uopValid, 0);
      chk("R9 no stall", stallUp, 0);
      chk("R9 ready", inReady, 1);
      @(negedge clk);
      chk("R9 still idle", uopValid, 0);
      return;
    end
    for (int i = 0; i < NREGS; i++) begin
      if (m[i]) begin
        chk("R2/R3 valid", uopValid, 1);
        chk("R4 reg", uopReg, i);
        chk("R5 addr", uopAddr, AW'(b + AW'(4 * k)));
        chk("R7 dir", uopStore, st);
        chk("R6 first", uopFirst, k == 0);
        chk("R6 last", uopLast, k == n - 1);
        chk("R8 stall", stallUp, 1);
        chk("R8 not ready", inReady, 0);
        // Offer a stray instruction while busy; it must be ignored (R8).
        if (k == 0 && n > 1) begin
          inValid = 1'b1; inMask = ~m; inStore = ~st;
        end else begin
          inValid = 1'b0;
        end
        k++;
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    chk("R3 end", uopValid, 0);
    chk("R8 stall drop", stallUp, 0);
    chk("R8 ready back", inReady, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", inReady, 1);
    chk("R1 valid", uopValid, 0);
    chk("R1 stall", stallUp, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after", inReady, 1);
    chk("R1 idle after", uopValid, 0);
    for (int m = 0; m < 256; m++) begin
      runInst(NREGS'(m), AW'(32'h1000 + m * 64), m[0]);
    end
    runInst(16'hFFFF, 32'hFFFF_FFF8, 1'b0);   // full list, address wraps
    runInst(16'h0FFF, 32'h0000_2000, 1'b1);   // twelve words
    runInst(16'h8001, 32'h0000_0040, 1'b0);   // end bits
    runInst(16'h8000, 32'h0000_0100, 1'b1);   // single top register
    runInst(16'h0003, 32'h0000_0200, 1'b0);   // double-word
    runInst(16'hA5A5, 32'h0000_0300, 1'b1);
    runInst(16'h0000, 32'h0000_0400, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule